// File: doc/BRIEF.md
# Hashed Page Table Entry Matcher

This block builds the two doublewords of a hashed page table entry and then searches one entry group for an entry whose first doubleword matches. A request carries a virtual page number with its low 12 address bits already removed, a base page-size index, an actual page-size index, a two-bit segment-size code, a physical address and a flag that selects the primary or the secondary hash. On a start pulse the block captures the encoded match word (`enc_v_o`) and the encoded second doubleword (`enc_r_o`). It then reads the group one slot per clock, beginning at slot 0, through a read port with a combinational return path.

The compare tag is not a plain address. The low 23 virtual-address bits are dropped. Further low bits are cleared according to the base page size. The segment-size code sits in the top two bits, and a large-page flag is set for any page larger than 4 KB. Each page-size index maps to a page shift, an AVPN mask and an LP encoding. These values are held in a small register table that takes its default contents at reset.

The controller has three states. `S_IDLE` waits for `start_i`. The transition *launch* (IDLE to SCAN) captures the encoded words and the hash select. `S_SCAN` checks one slot per cycle. The transition *found* (SCAN to REPORT) is taken on a hit. The transition *exhausted* (SCAN to REPORT) is taken after the last slot is checked without a hit. `S_REPORT` drives `done_o` for one cycle, and the transition *retire* (REPORT to IDLE) follows unconditionally.

Top module: `hpte_group_matcher`

## Requirements
- R1: `enc_v_o[63:7]` holds bits 63:7 of `(((vpn >> 11) & ~M) << 7)`, where M is the AVPN mask of the base page size. The result is zero-extended.
- R2: `enc_v_o[63:62]` carries `seg_size_i` unchanged. Code 0 selects 256 MB segments and code 1 selects 1 TB segments.
- R3: `enc_v_o[2]` is 1 exactly when the actual page-size index is not 0 (4 KB). `enc_v_o[6:3]` and `enc_v_o[1:0]` are 0.
- R4: When the actual page-size index is 0, `enc_r_o` equals `pa_i & 64'h0FFF_FFFF_FFFF_F000`.
- R5: For any other actual size with shift S and LP code L, `enc_r_o` equals `(pa_i` with bits S-1:0 cleared`) | (L << 12)`.
- R6: After reset the page-size table holds the following entries. Index 0: 4 KB, shift 12, mask 0, LP 0. Index 1: 64 KB, shift 16, mask 0, LP 1. Index 2: 16 MB, shift 24, mask 1, LP 0. Index 3: 16 GB, shift 34, mask 0x7FF, LP 3.
- R7: A slot matches only when all three of these hold: its bits 63:7 equal `enc_v_o[63:7]`; its bit 0 (valid) is 1; its bit 1 (secondary) equals the `want_sec_i` captured at start. Bits 6:2 of the slot are ignored.
- R8: Slots are read in ascending order from 0. The first matching slot is reported on `hit_slot_o` together with `hit_o`=1.
- R9: If the hit is at slot k, `done_o` pulses for one cycle, k+1 clock edges after the edge that accepts `start_i`. On a miss this delay is 8 edges and `hit_o`=0.
- R10: A start pulse that arrives while `busy_o` is 1 has no effect. The encoded words stay unchanged and no extra `done_o` is produced.
- R11: During and after reset the outputs are as follows: `busy_o`, `done_o`, `hit_o` and `grp_rd_o` are 0, and both encoded words are 0.
- R12: During a scan `grp_rd_o` is 1, and `grp_addr_o` advances by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted in IDLE only |
| vpn_i | input | 64 | Virtual page number with the low 12 address bits removed |
| base_psize_i | input | 2 | Base page-size index |
| act_psize_i | input | 2 | Actual page-size index |
| seg_size_i | input | 2 | Segment-size code |
| pa_i | input | 64 | Physical address |
| want_sec_i | input | 1 | Required value of the secondary-hash bit |
| grp_rd_o | output | 1 | Group read strobe |
| grp_addr_o | output | 3 | Slot index being read |
| grp_dw0_i | input | 64 | First doubleword of the addressed slot, same cycle |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | A matching slot was found |
| hit_slot_o | output | 3 | Index of the first matching slot |
| enc_v_o | output | 64 | Encoded first doubleword |
| enc_r_o | output | 64 | Encoded second doubleword |

## Verification
There are three kinds of internal fault to look for. A corrupted slot counter or a wrong stop condition shows at `grp_addr_o` within one cycle of the fault. It also shows as a `done_o` pulse on the wrong edge, which the bench measures against the k+1 rule. A wrong page-size table entry or a wrong encoder path shows on `enc_v_o` or `enc_r_o` one cycle after start, and it can also turn a hit into a miss. A state register that fails to leave REPORT, or that accepts a start while busy, shows as an unexpected or missing `done_o` pulse, or as encoded words that change under a busy request.

// File: rtl/hpte_pkg.sv
package hpte_pkg;

    localparam int DW_W       = 64;
    localparam int NUM_PSIZES = 4;
    localparam int PS_W       = $clog2(NUM_PSIZES);
    localparam int SHIFT_W    = 6;
    localparam int AVPNM_W    = 16;
    localparam int LP_W       = 8;
    localparam int AVA_DROP   = 11;   // 23 dropped VA bits minus the 12 already gone
    localparam int TAG_LSB    = 7;    // tag compare starts here
    localparam int LP_LSB     = 12;
    localparam int SEG_LSB    = 62;
    localparam int LARGE_BIT  = 2;
    localparam int SEC_BIT    = 1;
    localparam int VALID_BIT  = 0;
    localparam logic [DW_W-1:0] RPN_MASK = 64'h0FFF_FFFF_FFFF_F000;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [AVPNM_W-1:0] avpnm;
        logic [LP_W-1:0]    lpenc;
    } psize_ent_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SCAN   = 2'd1,
        S_REPORT = 2'd2
    } scan_state_e;

    function automatic psize_ent_t psize_default(input int idx);
        psize_ent_t e;
        case (idx)
            1: begin e.shift = 6'd16; e.avpnm = 16'h0000; e.lpenc = 8'd1; end
            2: begin e.shift = 6'd24; e.avpnm = 16'h0001; e.lpenc = 8'd0; end
            3: begin e.shift = 6'd34; e.avpnm = 16'h07FF; e.lpenc = 8'd3; end
            default: begin e.shift = 6'd12; e.avpnm = 16'h0000; e.lpenc = 8'd0; end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/hpte_psize_table.sv
module hpte_psize_table
    import hpte_pkg::*;
#(
    parameter int N_SIZES = NUM_PSIZES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(N_SIZES)-1:0]  base_idx_i,
    input  logic [$clog2(N_SIZES)-1:0]  act_idx_i,
    output psize_ent_t                  base_ent_o,
    output psize_ent_t                  act_ent_o
);

    psize_ent_t tbl_q [N_SIZES];

    for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[gi] <= psize_default(gi);
            end
        end
    end

    always_comb begin
        base_ent_o = tbl_q[base_idx_i];
        act_ent_o  = tbl_q[act_idx_i];
    end

endmodule

// File: rtl/hpte_word_encoder.sv
module hpte_word_encoder
    import hpte_pkg::*;
(
    input  logic [DW_W-1:0] vpn_i,
    input  logic [DW_W-1:0] pa_i,
    input  logic [1:0]      seg_i,
    input  logic            act_small_i,
    input  psize_ent_t      base_ent_i,
    input  psize_ent_t      act_ent_i,
    output logic [DW_W-1:0] v_word_o,
    output logic [DW_W-1:0] r_word_o
);

    logic [DW_W-1:0] mask_ext;
    logic [DW_W-1:0] ava;
    logic [DW_W-1:0] page_mask;
    logic [DW_W-1:0] lp_field;

    always_comb begin
        mask_ext  = {{(DW_W-AVPNM_W){1'b0}}, base_ent_i.avpnm};
        ava       = ((vpn_i >> AVA_DROP) & ~mask_ext) << TAG_LSB;
        v_word_o  = ava;
        v_word_o[DW_W-1:SEG_LSB] = seg_i;
        v_word_o[LARGE_BIT]      = ~act_small_i;

        page_mask = (64'd1 << act_ent_i.shift) - 64'd1;
        lp_field  = {{(DW_W-LP_W){1'b0}}, act_ent_i.lpenc} << LP_LSB;
        if (act_small_i) begin
            r_word_o = pa_i & RPN_MASK;
        end else begin
            r_word_o = (pa_i & ~page_mask) | lp_field;
        end
    end

endmodule

// File: rtl/hpte_slot_cmp.sv
module hpte_slot_cmp
    import hpte_pkg::*;
(
    input  logic [DW_W-1:0] slot_i,
    input  logic [DW_W-1:0] tag_i,
    input  logic            want_sec_i,
    output logic            match_o
);

    logic tag_eq;

    always_comb begin
        tag_eq  = (slot_i[DW_W-1:TAG_LSB] == tag_i[DW_W-1:TAG_LSB]);
        match_o = tag_eq && slot_i[VALID_BIT] && (slot_i[SEC_BIT] == want_sec_i);
    end

endmodule

// File: rtl/hpte_group_matcher.sv
module hpte_group_matcher
    import hpte_pkg::*;
#(
    parameter int GROUP_SIZE = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [63:0]                   vpn_i,
    input  logic [1:0]                    base_psize_i,
    input  logic [1:0]                    act_psize_i,
    input  logic [1:0]                    seg_size_i,
    input  logic [63:0]                   pa_i,
    input  logic                          want_sec_i,
    output logic                          grp_rd_o,
    output logic [$clog2(GROUP_SIZE)-1:0] grp_addr_o,
    input  logic [63:0]                   grp_dw0_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          hit_o,
    output logic [$clog2(GROUP_SIZE)-1:0] hit_slot_o,
    output logic [63:0]                   enc_v_o,
    output logic [63:0]                   enc_r_o
);

    localparam int SLOT_W = $clog2(GROUP_SIZE);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SIZE - 1);

    scan_state_e       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] hit_slot_q;
    logic              hit_q;
    logic              sec_q;
    logic [DW_W-1:0]   v_q, r_q;

    psize_ent_t        base_ent, act_ent;
    logic [DW_W-1:0]   v_comb, r_comb;
    logic              slot_match;
    logic              last_slot;
    logic              launch;

    hpte_psize_table #(.N_SIZES(NUM_PSIZES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_idx_i (base_psize_i),
        .act_idx_i  (act_psize_i),
        .base_ent_o (base_ent),
        .act_ent_o  (act_ent)
    );

    hpte_word_encoder u_enc (
        .vpn_i       (vpn_i),
        .pa_i        (pa_i),
        .seg_i       (seg_size_i),
        .act_small_i (act_psize_i == '0),
        .base_ent_i  (base_ent),
        .act_ent_i   (act_ent),
        .v_word_o    (v_comb),
        .r_word_o    (r_comb)
    );

    hpte_slot_cmp u_cmp (
        .slot_i     (grp_dw0_i),
        .tag_i      (v_q),
        .want_sec_i (sec_q),
        .match_o    (slot_match)
    );

    assign last_slot = (slot_q == LAST_SLOT);
    assign launch    = (state_q == S_IDLE) && start_i;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_SCAN;                       // launch
            S_SCAN:   if (slot_match || last_slot) state_d = S_REPORT;     // found / exhausted
            S_REPORT: state_d = S_IDLE;                                    // retire
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            slot_q     <= '0;
            hit_slot_q <= '0;
            hit_q      <= 1'b0;
            sec_q      <= 1'b0;
            v_q        <= '0;
            r_q        <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                v_q    <= v_comb;
                r_q    <= r_comb;
                sec_q  <= want_sec_i;
                slot_q <= '0;
                hit_q  <= 1'b0;
            end else if (state_q == S_SCAN) begin
                slot_q <= slot_q + 1'b1;
                if (slot_match) begin
                    hit_q      <= 1'b1;
                    hit_slot_q <= slot_q;
                end
            end
        end
    end

    // output decode
    always_comb begin
        busy_o     = (state_q != S_IDLE);
        grp_rd_o   = (state_q == S_SCAN);
        done_o     = (state_q == S_REPORT);
        grp_addr_o = slot_q;
        hit_o      = hit_q;
        hit_slot_o = hit_slot_q;
        enc_v_o    = v_q;
        enc_r_o    = r_q;
    end

endmodule

// File: rtl/hpte_matcher_chk.sv
module hpte_matcher_chk #(
    parameter int GROUP_SIZE = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start_i,
    input logic                          grp_rd_o,
    input logic [$clog2(GROUP_SIZE)-1:0] grp_addr_o,
    input logic [63:0]                   grp_dw0_i,
    input logic                          busy_o,
    input logic                          done_o,
    input logic                          hit_o,
    input logic [63:0]                   enc_v_o
);

    localparam int SLOT_W = $clog2(GROUP_SIZE);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_miss_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !hit_o) |-> ($past(grp_addr_o) == SLOT_W'(GROUP_SIZE - 1)));

    assert_first_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_rd_o) |-> (grp_addr_o == '0));

    assert_addr_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_rd_o && $past(grp_rd_o)) |-> (grp_addr_o == $past(grp_addr_o) + 1'b1));

    assert_hit_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hit_o) |-> (($past(grp_dw0_i[63:7]) == enc_v_o[63:7]) && $past(grp_dw0_i[0])));

    assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (enc_v_o[1:0] == 2'b00 && enc_v_o[6:3] == 4'b0000));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(enc_v_o));

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !grp_rd_o));

endmodule

bind hpte_group_matcher hpte_matcher_chk #(.GROUP_SIZE(GROUP_SIZE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .grp_rd_o   (grp_rd_o),
    .grp_addr_o (grp_addr_o),
    .grp_dw0_i  (grp_dw0_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .hit_o      (hit_o),
    .enc_v_o    (enc_v_o)
);

// File: tb/tb_hpte_group_matcher.sv
`timescale 1ns/1ps
module tb_hpte_group_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] vpn_i = '0;
    logic [1:0]  base_psize_i = '0;
    logic [1:0]  act_psize_i = '0;
    logic [1:0]  seg_size_i = '0;
    logic [63:0] pa_i = '0;
    logic        want_sec_i = 1'b0;
    logic        grp_rd_o;
    logic [2:0]  grp_addr_o;
    logic [63:0] grp_dw0_i;
    logic        busy_o, done_o, hit_o;
    logic [2:0]  hit_slot_o;
    logic [63:0] enc_v_o, enc_r_o;

    logic [63:0] grp_mem [8];
    assign grp_dw0_i = grp_mem[grp_addr_o];

    always #2 clk = ~clk;

    hpte_group_matcher dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vpn_i(vpn_i),
        .base_psize_i(base_psize_i), .act_psize_i(act_psize_i),
        .seg_size_i(seg_size_i), .pa_i(pa_i), .want_sec_i(want_sec_i),
        .grp_rd_o(grp_rd_o), .grp_addr_o(grp_addr_o), .grp_dw0_i(grp_dw0_i),
        .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o), .hit_slot_o(hit_slot_o),
        .enc_v_o(enc_v_o), .enc_r_o(enc_r_o)
    );

    typedef struct {
        logic [63:0] v;
        logic [63:0] r;
        logic        hit;
        int          slot;
        int          lat;
        int          t0;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   pcnt = 0;
    bit   finished = 1'b0;

    always @(posedge clk) pcnt <= pcnt + 1;

    function automatic int ref_shift(input logic [1:0] i);
        case (i) 2'd1: return 16; 2'd2: return 24; 2'd3: return 34; default: return 12; endcase
    endfunction
    function automatic logic [63:0] ref_mask(input logic [1:0] i);
        case (i) 2'd2: return 64'h1; 2'd3: return 64'h7FF; default: return 64'h0; endcase
    endfunction
    function automatic logic [63:0] ref_lp(input logic [1:0] i);
        case (i) 2'd1: return 64'd1; 2'd3: return 64'd3; default: return 64'd0; endcase
    endfunction
    // R1 R2 R3 R6
    function automatic logic [63:0] ref_v(input logic [63:0] vpn, input logic [1:0] b,
                                          input logic [1:0] a, input logic [1:0] s);
        logic [63:0] t;
        t = ((vpn >> 11) & ~ref_mask(b)) << 7;
        t = t | ({62'd0, s} << 62);
        if (a != 2'd0) t = t | 64'h4;
        return t;
    endfunction
    // R4 R5 R6
    function automatic logic [63:0] ref_r(input logic [63:0] pa, input logic [1:0] a);
        logic [63:0] m;
        if (a == 2'd0) return pa & 64'h0FFF_FFFF_FFFF_F000;
        m = (64'd1 << ref_shift(a)) - 64'd1;
        return (pa & ~m) | (ref_lp(a) << 12);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n && grp_rd_o && exp_q.size() > 0) begin
            check(grp_addr_o == 3'(pcnt - exp_q[0].t0), "R12", "slot address",
                  64'(grp_addr_o), 64'(pcnt - exp_q[0].t0));
        end
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(enc_v_o == e.v, "R1", "encoded first word", enc_v_o, e.v);
                check(enc_r_o == e.r, "R5", "encoded second word", enc_r_o, e.r);
                check(hit_o == e.hit, "R7", "hit flag", 64'(hit_o), 64'(e.hit));
                if (e.hit)
                    check(hit_slot_o == 3'(e.slot), "R8", "hit slot", 64'(hit_slot_o), 64'(e.slot));
                check((pcnt - e.t0) == e.lat, "R9", "done latency", 64'(pcnt - e.t0), 64'(e.lat));
            end
        end
    end

    task automatic fill_junk(input logic [63:0] v);
        for (int i = 0; i < 8; i++) grp_mem[i] = (v ^ (64'h1 << (20 + i))) | 64'h1;
    endtask

    task automatic run_case(input logic [63:0] vpn, input logic [63:0] pa,
                            input logic [1:0] b, input logic [1:0] a, input logic [1:0] s,
                            input logic sec, input logic eh, input int eslot, input int elat,
                            input bit poke);
        exp_t e;
        e.v = ref_v(vpn, b, a, s);
        e.r = ref_r(pa, a);
        e.hit = eh;
        e.slot = eslot;
        e.lat = elat;
        @(negedge clk);
        vpn_i = vpn; pa_i = pa; base_psize_i = b; act_psize_i = a;
        seg_size_i = s; want_sec_i = sec; start_i = 1'b1;
        e.t0 = pcnt + 1;
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            vpn_i = ~vpn; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; vpn_i = vpn;
        end
        while (busy_o) begin
            if (poke && done_o) begin
                vpn_i = ~vpn; start_i = 1'b1;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        vpn_i = vpn;
        if (poke) begin
            check(enc_v_o == e.v, "R10", "word after ignored start", enc_v_o, e.v);
            check(busy_o == 1'b0, "R10", "idle after ignored start", 64'(busy_o), 64'd0);
        end
    endtask

    initial begin
        logic [63:0] v;
        for (int i = 0; i < 8; i++) grp_mem[i] = '0;
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && hit_o == 1'b0 && grp_rd_o == 1'b0,
              "R11", "flags in reset", {60'd0, busy_o, done_o, hit_o, grp_rd_o}, 64'd0);
        check(enc_v_o == '0 && enc_r_o == '0, "R11", "words in reset", enc_v_o | enc_r_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R11", "idle after reset",
              {62'd0, busy_o, done_o}, 64'd0);

        // 4 KB, 256 MB segment, hit at slot 3 (R4, R8)
        v = ref_v(64'h0000_1234_5678_9ABC, 2'd0, 2'd0, 2'd0);
        fill_junk(v);
        grp_mem[3] = v | 64'h1;
        run_case(64'h0000_1234_5678_9ABC, 64'hF123_4567_89AB_CDEF, 2'd0, 2'd0, 2'd0,
                 1'b0, 1'b1, 3, 4, 1'b0);

        // miss: invalid, wrong secondary, wrong segment (R7, R9)
        fill_junk(v);
        grp_mem[1] = v;
        grp_mem[2] = v | 64'h3;
        grp_mem[4] = (v ^ (64'h1 << 62)) | 64'h1;
        run_case(64'h0000_1234_5678_9ABC, 64'h0000_0000_0001_2000, 2'd0, 2'd0, 2'd0,
                 1'b0, 1'b0, 0, 8, 1'b0);

        // 64 KB, 1 TB segment, hit slot 0 with garbage low bits (R2, R3, R5, R7)
        v = ref_v(64'h0000_00FE_DCBA_9876, 2'd1, 2'd1, 2'd1);
        fill_junk(v);
        grp_mem[0] = v | 64'h7D;
        run_case(64'h0000_00FE_DCBA_9876, 64'h0000_0012_3456_789A, 2'd1, 2'd1, 2'd1,
                 1'b0, 1'b1, 0, 1, 1'b0);

        // 16 MB, masked AVPN bit, secondary hash, hit at last slot (R1, R6, R9)
        v = ref_v(64'h0000_0ABC_DEF0_0800, 2'd2, 2'd2, 2'd0);
        fill_junk(v);
        grp_mem[3] = v | (64'h1 << 7) | 64'h3;
        grp_mem[7] = v | 64'h3;
        run_case(64'h0000_0ABC_DEF0_0800, 64'h0000_0123_4567_89AB, 2'd2, 2'd2, 2'd0,
                 1'b1, 1'b1, 7, 8, 1'b0);

        // 16 GB, two matches, first reported (R5, R8)
        v = ref_v(64'h0003_0000_1234_5FFF, 2'd3, 2'd3, 2'd1);
        fill_junk(v);
        grp_mem[2] = v | 64'h1;
        grp_mem[5] = v | 64'h1;
        run_case(64'h0003_0000_1234_5FFF, 64'h0000_00AB_CDEF_1234, 2'd3, 2'd3, 2'd1,
                 1'b0, 1'b1, 2, 3, 1'b0);

        // 4 KB base, 64 KB actual (R3, R5)
        v = ref_v(64'h0000_0000_00CA_FE00, 2'd0, 2'd1, 2'd0);
        fill_junk(v);
        grp_mem[6] = v | 64'h1;
        run_case(64'h0000_0000_00CA_FE00, 64'h0000_0000_7654_3210, 2'd0, 2'd1, 2'd0,
                 1'b0, 1'b1, 6, 7, 1'b0);

        // start pulses while busy and at done (R10)
        v = ref_v(64'h0000_1234_5678_9ABC, 2'd0, 2'd0, 2'd0);
        fill_junk(v);
        grp_mem[3] = v | 64'h1;
        run_case(64'h0000_1234_5678_9ABC, 64'hF123_4567_89AB_CDEF, 2'd0, 2'd0, 2'd0,
                 1'b0, 1'b1, 3, 4, 1'b1);

        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R9", "all results returned", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule